// File: doc/BRIEF.md
# Drive Level Adjust Aggregator

During link training the sink reports, for each lane, the voltage-swing level and the pre-emphasis level it wants the source to use next. This block turns those per-lane requests into one common drive setting. It takes the strongest swing and the strongest pre-emphasis asked for by any active lane. It marks either one that has reached the top level. It then copies the resulting byte into every lane slot.

A controller places the adjust-request bytes and the active lane count on the inputs and pulses `start` for one cycle. One clock later `set_valid` pulses for a single cycle. The four training-set bytes appear on `drive_set` and stay there until the next start. Sending the bytes to the sink and programming the PHY are handled elsewhere.

Top module: `drive_adjust_merge`

## Requirements
- R1: After reset, `drive_set` is all zeros and `set_valid` is low.
- R2: `set_valid` is high in exactly the cycle after a cycle in which `start` was high, and low in every other cycle.
- R3: Lane n reads request byte n>>1, which is `adj_req[8*(n>>1)+7 : 8*(n>>1)]`. An even lane takes its swing from bits 1:0 and its pre-emphasis from bits 3:2. An odd lane takes its swing from bits 5:4 and its pre-emphasis from bits 7:6.
- R4: The swing field (bits 1:0) of the result is the largest swing requested by any active lane.
- R5: The pre-emphasis field (bits 4:3) of the result is the largest pre-emphasis requested by any active lane.
- R6: Bit 2 of the result is set exactly when the resulting swing equals 3.
- R7: Bit 5 of the result is set exactly when the resulting pre-emphasis equals 3.
- R8: All four bytes of `drive_set` (lane n in bits 8n+7:8n) carry the same value, and bits 7:6 of each byte are zero, whatever the lane count.
- R9: A lane whose index is at or above `lane_cnt` has no effect on the result. A count of 0 gives an all-zero byte. Counts of 4 to 7 make every lane active.
- R10: While `start` is low, `drive_set` holds its value, even when `adj_req` or `lane_cnt` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to compute a new setting |
| adj_req | input | 16 | Two adjust-request bytes, one per lane pair |
| lane_cnt | input | 3 | Number of active lanes |
| drive_set | output | 32 | Four identical training-set bytes, lane 0 in the low byte |
| set_valid | output | 1 | One-cycle strobe marking a fresh result |

## Verification
The assertions assume that `start` is a clean synchronous level after reset. Every other property is checked at the strobe or across cycles without a start, so they assume nothing about the request bytes or the lane count. The stimulus therefore drives arbitrary request bytes and every count from 0 to 7. It changes those inputs at the falling edge, only between starts, and sometimes while `start` is low, so that the hold property is actually exercised.

// File: rtl/dla_pkg.sv
package dla_pkg;
    localparam int LEVEL_W = 2;
    localparam int SET_W   = 8;
    localparam int PAIR_W  = 8;

    typedef logic [LEVEL_W-1:0] level_t;

    localparam level_t LEVEL_TOP = 2'd3;

    // Training-set byte: {2'b00, pre_max, pre[1:0], swing_max, swing[1:0]}
    function automatic logic [SET_W-1:0] pack_setting(level_t swing, level_t pre);
        return {2'b00, (pre == LEVEL_TOP), pre, (swing == LEVEL_TOP), swing};
    endfunction
endpackage

// File: rtl/dla_lane_field.sv
module dla_lane_field
    import dla_pkg::*;
#(
    parameter int LANE_IDX = 0
) (
    input  logic [PAIR_W-1:0] pair_byte,
    input  logic              active,
    output level_t            swing,
    output level_t            pre
);
    level_t swing_raw;
    level_t pre_raw;

    generate
        if (LANE_IDX % 2 == 1) begin : g_upper
            assign swing_raw = pair_byte[5:4];
            assign pre_raw   = pair_byte[7:6];
        end else begin : g_lower
            assign swing_raw = pair_byte[1:0];
            assign pre_raw   = pair_byte[3:2];
        end
    endgenerate

    assign swing = active ? swing_raw : '0;
    assign pre   = active ? pre_raw   : '0;
endmodule

// File: rtl/dla_level_max.sv
module dla_level_max
    import dla_pkg::*;
#(
    parameter int N = 4
) (
    input  level_t [N-1:0] levels,
    output level_t         peak
);
    always_comb begin
        peak = '0;
        for (int i = 0; i < N; i++) begin
            if (levels[i] > peak) begin
                peak = levels[i];
            end
        end
    end
endmodule

// File: rtl/drive_adjust_merge.sv
module drive_adjust_merge
    import dla_pkg::*;
#(
    parameter  int LANES = 4,
    localparam int PAIRS = (LANES + 1) / 2,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [PAIRS*PAIR_W-1:0] adj_req,
    input  logic [CNT_W-1:0]        lane_cnt,
    output logic [LANES*SET_W-1:0]  drive_set,
    output logic                    set_valid
);
    typedef struct packed {
        logic [LANES*SET_W-1:0] set;
        logic                   valid;
    } state_t;

    state_t state_d;
    state_t state_q;

    level_t [LANES-1:0] lane_swing;
    level_t [LANES-1:0] lane_pre;
    level_t             swing_peak;
    level_t             pre_peak;

    generate
        for (genvar n = 0; n < LANES; n++) begin : g_lane
            dla_lane_field #(.LANE_IDX(n)) u_field (
                .pair_byte (adj_req[(n/2)*PAIR_W +: PAIR_W]),
                .active    (CNT_W'(n) < lane_cnt),
                .swing     (lane_swing[n]),
                .pre       (lane_pre[n])
            );
        end
    endgenerate

    dla_level_max #(.N(LANES)) u_swing_max (
        .levels (lane_swing),
        .peak   (swing_peak)
    );

    dla_level_max #(.N(LANES)) u_pre_max (
        .levels (lane_pre),
        .peak   (pre_peak)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = start;
        if (start) begin
            state_d.set = {LANES{pack_setting(swing_peak, pre_peak)}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign drive_set = state_q.set;
    assign set_valid = state_q.valid;
endmodule

// File: rtl/drive_adjust_merge_chk.sv
module drive_adjust_merge_chk #(
    parameter int LANES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic [LANES*8-1:0]   drive_set,
    input logic                 set_valid
);
    // R2: strobe follows start by one cycle
    p_strobe_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> set_valid);
    p_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !set_valid);

    // R10: result held without start
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(drive_set));

    // R6 / R7: top-level flags agree with the level fields
    p_swing_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |-> (drive_set[2] == (drive_set[1:0] == 2'd3)));
    p_pre_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |-> (drive_set[5] == (drive_set[4:3] == 2'd3)));

    // R8: broadcast to every lane slot, unused bits clear
    generate
        for (genvar n = 1; n < LANES; n++) begin : g_bc
            p_broadcast_r8: assert property (@(posedge clk) disable iff (!rst_n)
                set_valid |-> (drive_set[n*8 +: 8] == drive_set[7:0]));
        end
    endgenerate
    p_top_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |-> (drive_set[7:6] == 2'b00));
endmodule

bind drive_adjust_merge drive_adjust_merge_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .drive_set (drive_set),
    .set_valid (set_valid)
);

// File: tb/drive_adjust_merge_tb.sv
`timescale 1ns/1ps
module drive_adjust_merge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] adj_req = '0;
    logic [2:0]  lane_cnt = '0;
    logic [31:0] drive_set;
    logic        set_valid;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    drive_adjust_merge u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .adj_req   (adj_req),
        .lane_cnt  (lane_cnt),
        .drive_set (drive_set),
        .set_valid (set_valid)
    );

    // Expected result from R3, R4, R5, R6, R7, R8, R9
    function automatic logic [31:0] expect_set(logic [15:0] a, int cnt);
        logic [1:0] sw = 0;
        logic [1:0] pe = 0;
        logic [7:0] b;
        for (int lane = 0; lane < 4; lane++) begin
            if (lane < cnt) begin
                logic [1:0] s, p;
                b = a[(lane/2)*8 +: 8];
                s = (lane % 2) ? b[5:4] : b[1:0];
                p = (lane % 2) ? b[7:6] : b[3:2];
                if (s > sw) sw = s;
                if (p > pe) pe = p;
            end
        end
        b = {2'b00, pe == 2'd3, pe, sw == 2'd3, sw};
        return {4{b}};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One compute: strobe, value, then hold with changed inputs
    task automatic run(string req, logic [15:0] a, int cnt);
        logic [31:0] exp;
        exp = expect_set(a, cnt);
        @(negedge clk);
        adj_req  = a;
        lane_cnt = 3'(cnt);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({"R2 ", req}, 32'(set_valid), 32'd1);
        check(req, drive_set, exp);
        adj_req  = a ^ 16'hffff;
        lane_cnt = 3'(cnt + 1);
        @(negedge clk);
        check("R2 strobe low", 32'(set_valid), 32'd0);
        check("R10 hold", drive_set, exp);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d5e));
        repeat (3) @(negedge clk);
        check("R1 reset set", drive_set, 32'h0);
        check("R1 reset valid", 32'(set_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", drive_set, 32'h0);

        // R3: each lane field alone at top level, all lanes active
        run("R3 lane0 swing", 16'h0003, 4);
        run("R3 lane0 pre",   16'h000c, 4);
        run("R3 lane1 swing", 16'h0030, 4);
        run("R3 lane1 pre",   16'h00c0, 4);
        run("R3 lane2 swing", 16'h0300, 4);
        run("R3 lane3 pre",   16'hc000, 4);
        // R4/R5: max across mixed lanes
        run("R4 R5 mixed", 16'h2146, 4);
        run("R6 R7 mid levels", 16'h9a9a, 4);
        // R9: inactive lanes ignored
        run("R9 lane3 ignored", 16'hf000, 3);
        run("R9 upper pair ignored", 16'hff11, 2);
        run("R9 count zero", 16'hffff, 0);
        run("R9 count seven", 16'h3000, 7);
        run("R8 single lane", 16'hfff6, 1);

        for (int i = 0; i < 200; i++) begin
            run("R4 R5 random", 16'($urandom), int'($urandom_range(0, 7)));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule